// File: doc/BRIEF.md
# Traffic Signal Phase Sequencer with Illegal-Code Recovery

This block steps a road signal through its phases: red, left-turn arrow, green, yellow, and back to red. Each phase holds for a dwell time set by its own parameter. A maintenance input overrides the normal cycle. While it is held, the signal shows flashing yellow or flashing red, picked by a select input. When it is released, the cycle starts again from red with a full red dwell.

The phase register is a 3-bit binary code. Six codes are used, so two are not. A bad power-up or a single flipped bit can put the register on one of those two codes. The block decodes both of them explicitly. While the register holds such a code, the lamps show red and an error flag is high. On the next clock edge the register returns to red and the dwell counter is cleared, so the machine can never get stuck.

The logic is split into three parts: a combinational next-state and dwell stage, a state register, and a lamp decoder. The lamp decoder depends only on the current phase code.

Top module: `sig_phase_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, lamp_o is 4'b0001 (red), flash_o is 0 and illegal_o is 0, whatever maint_i is.
- R2: lamp_o always has exactly one bit set. Bit 0 is red, bit 1 is yellow, bit 2 is green and bit 3 is the turn arrow.
- R3: With maint_i low, the lamps follow the order red, arrow, green, yellow, and then red again.
- R4: With maint_i low, each phase shows for exactly its dwell count of cycles: DWELL_RED, DWELL_ARROW, DWELL_GREEN and DWELL_YELLOW.
- R5: If maint_i is high at a clock edge, the next phase is flashing: yellow lamp when maint_sel_i is 0, red lamp when maint_sel_i is 1. flash_o is 1 only in these two phases, and the phase follows maint_sel_i at every edge while maint_i stays high.
- R6: If the block is flashing and maint_i is low at a clock edge, the next phase is red, and that red lasts a full DWELL_RED before the arrow.
- R7: While the phase code is 3'b110 or 3'b111, lamp_o is red, flash_o is 0 and illegal_o is 1. illegal_o is 0 for every legal code.
- R8: From an unused code, the next edge always loads red with the dwell cleared, even if maint_i is high. The red then lasts a full DWELL_RED (or gives way to flashing on the following edge if maint_i is high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| maint_i | input | 1 | Maintenance override; flashing while high |
| maint_sel_i | input | 1 | Flash colour: 0 yellow, 1 red |
| lamp_o | output | 4 | One-hot lamp drive {arrow, green, yellow, red} |
| flash_o | output | 1 | High in the two flashing phases |
| illegal_o | output | 1 | High while the phase code is unused |

## Verification
The bench writes each unused code into the phase register at every offset of the normal cycle, with maint_i both low and high. A design that left a code undecoded would stay stuck or wander to some other phase. One that kept the dwell count would cut the recovery red short. One that let maintenance take priority would go straight to flashing without passing through red. It also enters maintenance at every cycle offset and with both colours, and checks that red is re-entered with a full dwell. A wrong dwell compare shows up as a phase that is one cycle long or short against the arithmetic model of the cycle.

// File: rtl/sig_pkg.sv
package sig_pkg;

  typedef enum logic [2:0] {
    PH_RED         = 3'd0,
    PH_YELLOW      = 3'd1,
    PH_GREEN       = 3'd2,
    PH_FLASH_YEL   = 3'd3,
    PH_FLASH_RED   = 3'd4,
    PH_ARROW       = 3'd5
  } phase_e;

  localparam int unsigned PHASE_W = 3;
  localparam int unsigned LAMP_W  = 4;

  localparam logic [LAMP_W-1:0] LAMP_RED    = 4'b0001;
  localparam logic [LAMP_W-1:0] LAMP_YELLOW = 4'b0010;
  localparam logic [LAMP_W-1:0] LAMP_GREEN  = 4'b0100;
  localparam logic [LAMP_W-1:0] LAMP_ARROW  = 4'b1000;

  function automatic logic phase_legal(input logic [PHASE_W-1:0] code);
    return code <= PH_ARROW;
  endfunction

endpackage

// File: rtl/sig_next_state.sv
module sig_next_state
  import sig_pkg::*;
#(
  parameter int unsigned DWELL_RED    = 32,
  parameter int unsigned DWELL_ARROW  = 8,
  parameter int unsigned DWELL_GREEN  = 24,
  parameter int unsigned DWELL_YELLOW = 6,
  parameter int unsigned CNT_W        = 5
) (
  input  logic [PHASE_W-1:0] state_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               maint_i,
  input  logic               maint_sel_i,
  output logic [PHASE_W-1:0] state_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               illegal_o
);

  localparam logic [CNT_W-1:0] LAST_RED    = CNT_W'(DWELL_RED - 1);
  localparam logic [CNT_W-1:0] LAST_ARROW  = CNT_W'(DWELL_ARROW - 1);
  localparam logic [CNT_W-1:0] LAST_GREEN  = CNT_W'(DWELL_GREEN - 1);
  localparam logic [CNT_W-1:0] LAST_YELLOW = CNT_W'(DWELL_YELLOW - 1);

  logic [CNT_W-1:0]   last_cnt;
  logic [PHASE_W-1:0] succ;
  logic               dwell_done;

  // dwell limit and successor of each normal phase
  always_comb begin
    last_cnt = LAST_RED;
    succ     = PH_RED;
    unique case (state_i)
      PH_RED:    begin last_cnt = LAST_RED;    succ = PH_ARROW;  end
      PH_ARROW:  begin last_cnt = LAST_ARROW;  succ = PH_GREEN;  end
      PH_GREEN:  begin last_cnt = LAST_GREEN;  succ = PH_YELLOW; end
      PH_YELLOW: begin last_cnt = LAST_YELLOW; succ = PH_RED;    end
      default:   begin last_cnt = LAST_RED;    succ = PH_RED;    end
    endcase
  end

  assign dwell_done = (cnt_i == last_cnt);

  // priority: unused code, then maintenance, then dwell
  always_comb begin
    state_o   = state_i;
    cnt_o     = cnt_i + CNT_W'(1);
    illegal_o = 1'b0;
    if (!phase_legal(state_i)) begin
      state_o   = PH_RED;
      cnt_o     = '0;
      illegal_o = 1'b1;
    end else if (maint_i) begin
      state_o = maint_sel_i ? PH_FLASH_RED : PH_FLASH_YEL;
      cnt_o   = '0;
    end else if (state_i == PH_FLASH_YEL || state_i == PH_FLASH_RED) begin
      state_o = PH_RED;
      cnt_o   = '0;
    end else if (dwell_done) begin
      state_o = succ;
      cnt_o   = '0;
    end
  end

endmodule

// File: rtl/sig_state_reg.sv
module sig_state_reg
  import sig_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] state_d_i,
  input  logic [CNT_W-1:0]   cnt_d_i,
  output logic [PHASE_W-1:0] state_q_o,
  output logic [CNT_W-1:0]   cnt_q_o
);

  logic [PHASE_W-1:0] state_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_RED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d_i;
      cnt_q   <= cnt_d_i;
    end
  end

  assign state_q_o = state_q;
  assign cnt_q_o   = cnt_q;

endmodule

// File: rtl/sig_lamp_decode.sv
module sig_lamp_decode
  import sig_pkg::*;
(
  input  logic [PHASE_W-1:0] state_i,
  output logic [LAMP_W-1:0]  lamp_o,
  output logic               flash_o
);

  always_comb begin
    lamp_o  = LAMP_RED;
    flash_o = 1'b0;
    unique case (state_i)
      PH_RED:       lamp_o = LAMP_RED;
      PH_ARROW:     lamp_o = LAMP_ARROW;
      PH_GREEN:     lamp_o = LAMP_GREEN;
      PH_YELLOW:    lamp_o = LAMP_YELLOW;
      PH_FLASH_YEL: begin lamp_o = LAMP_YELLOW; flash_o = 1'b1; end
      PH_FLASH_RED: begin lamp_o = LAMP_RED;    flash_o = 1'b1; end
      default:      lamp_o = LAMP_RED; // unused codes fail safe
    endcase
  end

endmodule

// File: rtl/sig_phase_ctrl.sv
module sig_phase_ctrl
  import sig_pkg::*;
#(
  parameter int unsigned DWELL_RED    = 32,
  parameter int unsigned DWELL_ARROW  = 8,
  parameter int unsigned DWELL_GREEN  = 24,
  parameter int unsigned DWELL_YELLOW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              maint_i,
  input  logic              maint_sel_i,
  output logic [LAMP_W-1:0] lamp_o,
  output logic              flash_o,
  output logic              illegal_o
);

  localparam int unsigned MAX_RA    = (DWELL_RED > DWELL_ARROW) ? DWELL_RED : DWELL_ARROW;
  localparam int unsigned MAX_GY    = (DWELL_GREEN > DWELL_YELLOW) ? DWELL_GREEN : DWELL_YELLOW;
  localparam int unsigned MAX_DWELL = (MAX_RA > MAX_GY) ? MAX_RA : MAX_GY;
  localparam int unsigned CNT_W     = (MAX_DWELL > 2) ? $clog2(MAX_DWELL) : 1;

  logic [PHASE_W-1:0] state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  sig_next_state #(
    .DWELL_RED   (DWELL_RED),
    .DWELL_ARROW (DWELL_ARROW),
    .DWELL_GREEN (DWELL_GREEN),
    .DWELL_YELLOW(DWELL_YELLOW),
    .CNT_W       (CNT_W)
  ) u_next (
    .state_i    (state_q),
    .cnt_i      (cnt_q),
    .maint_i    (maint_i),
    .maint_sel_i(maint_sel_i),
    .state_o    (state_d),
    .cnt_o      (cnt_d),
    .illegal_o  (illegal_o)
  );

  sig_state_reg #(
    .CNT_W(CNT_W)
  ) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_d_i(state_d),
    .cnt_d_i  (cnt_d),
    .state_q_o(state_q),
    .cnt_q_o  (cnt_q)
  );

  sig_lamp_decode u_dec (
    .state_i(state_q),
    .lamp_o (lamp_o),
    .flash_o(flash_o)
  );

endmodule

// File: rtl/sig_phase_ctrl_chk.sv
module sig_phase_ctrl_chk
  import sig_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               maint_i,
  input logic [PHASE_W-1:0] state_q_i,
  input logic [LAMP_W-1:0]  lamp_o,
  input logic               flash_o,
  input logic               illegal_o
);

  p_lamp_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(lamp_o));

  p_arrow_to_green_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_o == LAMP_ARROW) |=> (lamp_o == LAMP_ARROW || lamp_o == LAMP_GREEN || flash_o || illegal_o));

  p_flash_needs_maint_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_o |-> $past(maint_i));

  p_release_to_red_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_o && !maint_i) |=> (lamp_o == LAMP_RED && !flash_o));

  p_illegal_shows_red_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (lamp_o == LAMP_RED && !flash_o));

  p_illegal_recovers_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q_i > PH_ARROW) |=> (state_q_i == PH_RED && !illegal_o));

endmodule

bind sig_phase_ctrl sig_phase_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .maint_i  (maint_i),
  .state_q_i(state_q),
  .lamp_o   (lamp_o),
  .flash_o  (flash_o),
  .illegal_o(illegal_o)
);

// File: tb/sig_phase_ctrl_tb_top.sv
`timescale 1ns/1ps
module sig_phase_ctrl_tb_top;

  localparam int DR = 3;
  localparam int DA = 2;
  localparam int DG = 4;
  localparam int DY = 2;
  localparam int P  = DR + DA + DG + DY;
  localparam realtime T_CLK = 4.0;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       maint = 1'b0;
  logic       sel = 1'b0;
  logic [3:0] lamp;
  logic       flash;
  logic       ill;

  int n_vec = 0;
  int n_bad = 0;

  always #(T_CLK/2) clk = ~clk;

  sig_phase_ctrl #(
    .DWELL_RED(DR), .DWELL_ARROW(DA), .DWELL_GREEN(DG), .DWELL_YELLOW(DY)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .maint_i(maint), .maint_sel_i(sel),
    .lamp_o(lamp), .flash_o(flash), .illegal_o(ill)
  );

  function automatic logic [3:0] exp_lamp(input int t);
    int off;
    off = t % P;
    if (off < DR)           return 4'b0001;
    if (off < DR + DA)      return 4'b1000;
    if (off < DR + DA + DG) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic chk(input string req, input logic [3:0] el, input logic ef, input logic ei);
    n_vec++;
    if (lamp !== el || flash !== ef || ill !== ei) begin
      n_bad++;
      $display("FAIL %s: lamp=%b flash=%b illegal=%b expected lamp=%b flash=%b illegal=%b",
               req, lamp, flash, ill, el, ef, ei);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  // reset with maint high to show it has no effect (R1)
  task automatic do_reset();
    rst_ni = 1'b0;
    maint  = 1'b1;
    sel    = 1'b1;
    @(negedge clk);
    #0.5;
    chk("R1 in reset", 4'b0001, 1'b0, 1'b0);
    maint = 1'b0;
    sel   = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    #0.5;
    chk("R1 after reset", 4'b0001, 1'b0, 1'b0);
  endtask

  task automatic advance(input int cycles);
    for (int i = 1; i <= cycles; i++) begin
      step();
      chk("R3,R4 cycle", exp_lamp(i), 1'b0, 1'b0);
    end
  endtask

  // expects current sample to be first red cycle
  task automatic full_red_then_arrow(input string req);
    for (int k = 1; k <= DR; k++) begin
      step();
      chk(req, (k < DR) ? 4'b0001 : 4'b1000, 1'b0, 1'b0);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(T_CLK * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R2 R3 R4: two full cycles from reset
    do_reset();
    advance(2 * P);

    // R5 R6: maintenance entry at every offset, both colours
    for (int s = 0; s < 2; s++) begin
      for (int o = 0; o < P; o++) begin
        do_reset();
        advance(o);
        maint = 1'b1;
        sel   = s[0];
        step();
        chk("R5 enter flash", s[0] ? 4'b0001 : 4'b0010, 1'b1, 1'b0);
        sel = ~s[0];
        step();
        chk("R5 follow select", s[0] ? 4'b0010 : 4'b0001, 1'b1, 1'b0);
        sel = s[0];
        step();
        chk("R5 hold flash", s[0] ? 4'b0001 : 4'b0010, 1'b1, 1'b0);
        maint = 1'b0;
        step();
        chk("R6 release to red", 4'b0001, 1'b0, 1'b0);
        full_red_then_arrow("R6 full red dwell");
      end
    end

    // R7 R8: force each unused code at every offset, maint low and high
    for (int c = 6; c < 8; c++) begin
      for (int m = 0; m < 2; m++) begin
        for (int o = 0; o < P; o++) begin
          do_reset();
          advance(o);
          maint = m[0];
          sel   = 1'b0;
          if (c == 6) force dut_i.u_reg.state_q = 3'b110;
          else        force dut_i.u_reg.state_q = 3'b111;
          #0.2;
          release dut_i.u_reg.state_q;
          #0.2;
          chk("R7 unused code shows red", 4'b0001, 1'b0, 1'b1);
          step();
          chk("R8 recovered to red", 4'b0001, 1'b0, 1'b0);
          if (m == 1) begin
            step();
            chk("R8 then flash", 4'b0010, 1'b1, 1'b0);
            maint = 1'b0;
            step();
            chk("R6 red after flash", 4'b0001, 1'b0, 1'b0);
            full_red_then_arrow("R6 full red dwell");
          end else begin
            full_red_then_arrow("R8 dwell cleared");
          end
        end
      end
    end

    summary();
    $finish;
  end

endmodule